// File: doc/BRIEF.md
# Flash Program/Erase Guard

This block decides whether a flash array's program/erase sequencer may run. It holds a small register set that the CPU writes through a plain write/read port. That set has a control register with a write-enable gate and program and erase request bits, a status register with a sticky error flag, and two erase-mask registers that give one bit to each of sixteen blocks. From these registers and from system events, the block drives program-mode and erase-mode enables and a per-block erase-enable vector.

Protection works in three ways. First, a reset or a watchdog reset returns every register to zero, and entry into any low-power mode clears the control and mask state. Second, software must open the write-enable gate before it can request a mode, and it selects the erasable blocks through the mask. Third, the block traps illegal CPU activity while an operation runs: a flash read, an exception entry, a sleep instruction or a bus release. Any of these ends the operation and sets an error flag that only reset clears.

Top module: `flash_guard`

## Requirements
- R1: When `rst` or `wdog_rst` is high at a clock edge, every register is zero after that edge, including the error flag. All outputs, including `reg_rdata`, then read zero.
- R2: If any bit of `lp_enter` is high at an edge, the write-enable, program and erase bits and both mask registers are zero after it, and register writes in that cycle are lost. The error flag is kept.
- R3: Control register fields are: bit 0 write-enable, bit 1 program request, bit 2 erase request. A control write takes effect only when the written bit 0 is 1 and the write-enable bit was already 1 before the write. Otherwise program and erase become 0.
- R4: A control write that sets both bit 1 and bit 2 leaves program and erase unchanged. Its bit 0 is still stored, and writing 0 there ends any mode.
- R5: `blk_erase_en[8*k+b]` is 1 exactly when erase mode is on and bit b of mask register k is 1. The low mask is at address 2 and the high mask at address 3. A zero mask keeps every block off.
- R6: When program or erase is on and any of `flash_rd`, `exc_enter`, `sleep_exec` or `bus_release` is high, the error flag is 1 after that edge and both modes are 0.
- R7: The same four strobes have no effect while neither mode is on.
- R8: The error flag stays 1 until R1. While it is 1, program and erase remain 0 and mode requests are ignored. Writes to address 1 change nothing.
- R9: When `reg_re` is high, `reg_rdata` takes the value of the addressed register as it was before that edge. Address 0 reads {5'b0, erase, program, write-enable}, address 1 reads {error, 7'b0}, and addresses 2 and 3 read the masks. With `reg_re` low, `reg_rdata` holds its value.
- R10: Priority runs from reset, to low-power entry, to a trap, to a register write. A trap in the same cycle as low-power entry still sets the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wdog_rst | input | 1 | Watchdog overflow reset, same effect as rst |
| lp_enter | input | 5 | One bit per low-power mode being entered |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| flash_rd | input | 1 | CPU read of the flash array (fetch, vector or data) |
| exc_enter | input | 1 | Non-reset exception entry |
| sleep_exec | input | 1 | Sleep instruction executed |
| bus_release | input | 1 | Bus ownership released |
| prog_en | output | 1 | Program mode enable |
| erase_en | output | 1 | Erase mode enable |
| blk_erase_en | output | 16 | Per-block erase enable |
| err_flag | output | 1 | Sticky error flag |

## Verification
The state that is hardest to reach is a trap that fires during a live operation. To reach it, the bench must pass a reset, then one write that opens the gate, then a second write that requests a mode. Only after that can a strobe arrive. A random stream rarely produces this sequence, and once the flag is set it locks out every later attempt until a reset. The stimulus therefore favours control writes with bit 0 set and keeps resets fairly frequent. Directed sequences drive each of the four strobes through a fresh operation, and they also test a strobe that arrives together with low-power entry.

// File: rtl/fg_pkg.sv
package fg_pkg;
  // control register field positions
  localparam int BIT_WEN   = 0;
  localparam int BIT_PROG  = 1;
  localparam int BIT_ERASE = 2;
  // address map
  localparam int ADR_CTRL  = 0;
  localparam int ADR_STAT  = 1;
  localparam int ADR_MASK0 = 2;

  typedef struct packed {
    logic wen;
    logic prog;
    logic erase;
  } fg_mode_t;
endpackage

// File: rtl/fg_trap.sv
module fg_trap #(
  parameter int N_EV = 4
) (
  input  logic            active,
  input  logic [N_EV-1:0] ev,
  output logic            trip
);
  // an illegal event only matters while an operation runs
  assign trip = active & (|ev);
endmodule

// File: rtl/fg_mode_ctl.sv
module fg_mode_ctl
  import fg_pkg::*;
(
  input  logic       clk,
  input  logic       clr,
  input  logic       lp,
  input  logic       we_ctrl,
  input  logic [2:0] wd,
  input  logic       trip,
  output fg_mode_t   mode_q,
  output fg_mode_t   mode_nxt,
  output logic       err_q
);
  logic err_nxt;

  always_comb begin
    mode_nxt = mode_q;
    err_nxt  = err_q | trip;
    if (lp) begin
      mode_nxt = '0;
    end else if (err_q || trip) begin
      mode_nxt.prog  = 1'b0;
      mode_nxt.erase = 1'b0;
      if (we_ctrl) mode_nxt.wen = wd[BIT_WEN];
    end else if (we_ctrl) begin
      mode_nxt.wen = wd[BIT_WEN];
      if (!wd[BIT_WEN]) begin
        mode_nxt.prog  = 1'b0;
        mode_nxt.erase = 1'b0;
      end else if (!(wd[BIT_PROG] && wd[BIT_ERASE])) begin
        mode_nxt.prog  = wd[BIT_PROG]  & mode_q.wen;
        mode_nxt.erase = wd[BIT_ERASE] & mode_q.wen;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      mode_q <= mode_nxt;
      err_q  <= err_nxt;
    end
  end

  assert_excl_R4: assert property (@(posedge clk) disable iff (clr)
    !(mode_q.prog && mode_q.erase));
  assert_sticky_R8: assert property (@(posedge clk) disable iff (clr)
    err_q |=> err_q);
  assert_hold_R8: assert property (@(posedge clk) disable iff (clr)
    err_q |-> (!mode_q.prog && !mode_q.erase));
  assert_trip_R6: assert property (@(posedge clk) disable iff (clr)
    trip |=> (err_q && !mode_q.prog && !mode_q.erase));
  assert_lp_R2: assert property (@(posedge clk) disable iff (clr)
    lp |=> (!mode_q.wen && !mode_q.prog && !mode_q.erase));
  assert_gate_R3: assert property (@(posedge clk) disable iff (clr)
    ($rose(mode_q.prog) || $rose(mode_q.erase)) |-> $past(mode_q.wen));
endmodule

// File: rtl/fg_blk_regs.sv
module fg_blk_regs #(
  parameter int REG_W  = 8,
  parameter int N_REGS = 2,
  parameter int ADDR_W = 2,
  parameter int BASE   = 2
) (
  input  logic                    clk,
  input  logic                    clr,
  input  logic                    lp,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [REG_W-1:0]        wdata,
  input  logic                    erase_nxt,
  output logic [N_REGS*REG_W-1:0] blk_q,
  output logic [N_REGS*REG_W-1:0] blk_en_q
);
  for (genvar i = 0; i < N_REGS; i++) begin : g_mask
    logic [REG_W-1:0] q, en, nxt;
    always_comb begin
      if (lp) nxt = '0;
      else if (we && waddr == ADDR_W'(BASE + i)) nxt = wdata;
      else nxt = q;
    end
    always_ff @(posedge clk) begin
      if (clr) begin
        q  <= '0;
        en <= '0;
      end else begin
        q  <= nxt;
        en <= erase_nxt ? nxt : '0;
      end
    end
    assign blk_q[i*REG_W +: REG_W]    = q;
    assign blk_en_q[i*REG_W +: REG_W] = en;
  end

  assert_blk_lp_R2: assert property (@(posedge clk) disable iff (clr)
    lp |=> (blk_q == '0));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int N_MASK = 2,
  parameter int LP_N   = 5,
  localparam int ADDR_W = $clog2(N_MASK + 2),
  localparam int N_BLK  = N_MASK * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wdog_rst,
  input  logic [LP_N-1:0]   lp_enter,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              flash_rd,
  input  logic              exc_enter,
  input  logic              sleep_exec,
  input  logic              bus_release,
  output logic              prog_en,
  output logic              erase_en,
  output logic [N_BLK-1:0]  blk_erase_en,
  output logic              err_flag
);
  localparam int N_EV = 4;

  logic            clr, lp, trip, err_q, we_ctrl;
  fg_mode_t        mode_q, mode_nxt;
  logic [N_BLK-1:0] blk_q;
  logic [REG_W-1:0] rd_mux;

  assign clr     = rst | wdog_rst;
  assign lp      = |lp_enter;
  assign we_ctrl = reg_we && (reg_addr == ADDR_W'(ADR_CTRL));

  fg_trap #(.N_EV(N_EV)) u_trap (
    .active (mode_q.prog | mode_q.erase),
    .ev     ({bus_release, sleep_exec, exc_enter, flash_rd}),
    .trip   (trip)
  );

  fg_mode_ctl u_mode (
    .clk      (clk),
    .clr      (clr),
    .lp       (lp),
    .we_ctrl  (we_ctrl),
    .wd       (reg_wdata[2:0]),
    .trip     (trip),
    .mode_q   (mode_q),
    .mode_nxt (mode_nxt),
    .err_q    (err_q)
  );

  fg_blk_regs #(.REG_W(REG_W), .N_REGS(N_MASK), .ADDR_W(ADDR_W), .BASE(ADR_MASK0)) u_blk (
    .clk       (clk),
    .clr       (clr),
    .lp        (lp),
    .we        (reg_we),
    .waddr     (reg_addr),
    .wdata     (reg_wdata),
    .erase_nxt (mode_nxt.erase),
    .blk_q     (blk_q),
    .blk_en_q  (blk_erase_en)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(ADR_CTRL)) begin
      rd_mux[BIT_WEN]   = mode_q.wen;
      rd_mux[BIT_PROG]  = mode_q.prog;
      rd_mux[BIT_ERASE] = mode_q.erase;
    end else if (reg_addr == ADDR_W'(ADR_STAT)) begin
      rd_mux[REG_W-1] = err_q;
    end
    for (int i = 0; i < N_MASK; i++)
      if (reg_addr == ADDR_W'(ADR_MASK0 + i)) rd_mux = blk_q[i*REG_W +: REG_W];
  end

  always_ff @(posedge clk) begin
    if (clr) reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end

  assign prog_en  = mode_q.prog;
  assign erase_en = mode_q.erase;
  assign err_flag = err_q;

  assert_mask_R5: assert property (@(posedge clk) disable iff (clr)
    (blk_erase_en != '0) |-> (erase_en && ((blk_erase_en & ~blk_q) == '0)));
  assert_quiet_R7: assert property (@(posedge clk) disable iff (clr)
    (!prog_en && !erase_en && !err_flag && !lp) |=> !err_flag);
  assert_reset_R1: assert property (@(posedge clk)
    clr |=> (!prog_en && !erase_en && !err_flag && blk_erase_en == '0));
endmodule

// File: tb/sim_flash_guard.sv
`timescale 1ns/1ps
module sim_flash_guard;
  localparam int REG_W = 8, N_MASK = 2, N_BLK = 16;

  logic clk = 1'b0;
  logic rst, wdog_rst, reg_we, reg_re, flash_rd, exc_enter, sleep_exec, bus_release;
  logic [4:0] lp_enter;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic prog_en, erase_en, err_flag;
  logic [N_BLK-1:0] blk_erase_en;

  always #2.5 clk = ~clk;

  flash_guard u0 (
    .clk(clk), .rst(rst), .wdog_rst(wdog_rst), .lp_enter(lp_enter),
    .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .flash_rd(flash_rd), .exc_enter(exc_enter),
    .sleep_exec(sleep_exec), .bus_release(bus_release), .prog_en(prog_en),
    .erase_en(erase_en), .blk_erase_en(blk_erase_en), .err_flag(err_flag)
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit m_wen, m_prog, m_erase, m_err;
  logic [7:0] m_blk [N_MASK];
  logic [7:0] m_rd;
  logic [N_BLK-1:0] m_blken;

  function automatic logic [7:0] rd_model(input logic [1:0] a);
    case (a)
      2'd0: return {5'b0, m_erase, m_prog, m_wen};
      2'd1: return {m_err, 7'b0};
      default: return m_blk[a - 2];
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step();
    bit act, trip, np, ne, nw, ctl;
    logic [3:0] ev;
    string tag;
    ev   = {bus_release, sleep_exec, exc_enter, flash_rd};
    act  = m_prog | m_erase;
    trip = act && (ev != 0);
    ctl  = reg_we && reg_addr == 2'd0;
    if (rst || wdog_rst) tag = "R1";
    else if (lp_enter != 0 && (trip || reg_we)) tag = "R10";
    else if (lp_enter != 0) tag = "R2";
    else if (trip) tag = "R6";
    else if (ev != 0) tag = "R7";
    else if (m_err) tag = "R8";
    else if (ctl && reg_wdata[1] && reg_wdata[2]) tag = "R4";
    else if (ctl) tag = "R3";
    else if (reg_we) tag = "R5";
    else tag = "R9";
    if (rst || wdog_rst) begin
      {m_wen, m_prog, m_erase, m_err} = '0;
      for (int i = 0; i < N_MASK; i++) m_blk[i] = '0;
      m_rd = '0;
      m_blken = '0;
    end else begin
      if (reg_re) m_rd = rd_model(reg_addr);
      nw = m_wen; np = m_prog; ne = m_erase;
      if (lp_enter != 0) begin
        nw = 0; np = 0; ne = 0;
      end else if (m_err || trip) begin
        np = 0; ne = 0;
        if (ctl) nw = reg_wdata[0];
      end else if (ctl) begin
        nw = reg_wdata[0];
        if (!reg_wdata[0]) begin np = 0; ne = 0; end
        else if (!(reg_wdata[1] && reg_wdata[2])) begin
          np = reg_wdata[1] && m_wen;
          ne = reg_wdata[2] && m_wen;
        end
      end
      for (int i = 0; i < N_MASK; i++) begin
        if (lp_enter != 0) m_blk[i] = '0;
        else if (reg_we && reg_addr == 2'(2 + i)) m_blk[i] = reg_wdata;
      end
      m_err = m_err | trip;
      m_wen = nw; m_prog = np; m_erase = ne;
      for (int i = 0; i < N_MASK; i++)
        for (int b = 0; b < REG_W; b++) m_blken[i*REG_W + b] = ne & m_blk[i][b];
    end
    @(posedge clk);
    @(negedge clk);
    chk(tag, "prog_en", 32'(prog_en), 32'(m_prog));
    chk(tag, "erase_en", 32'(erase_en), 32'(m_erase));
    chk(tag, "err_flag", 32'(err_flag), 32'(m_err));
    chk(tag, "blk_erase_en", 32'(blk_erase_en), 32'(m_blken));
    chk(tag, "reg_rdata", 32'(reg_rdata), 32'(m_rd));
  endtask

  task automatic go(input bit r, input bit wr, input bit we, input bit re,
                    input int a, input int d, input int ev, input int lp);
    rst = r; wdog_rst = wr; reg_we = we; reg_re = re;
    reg_addr = 2'(a); reg_wdata = 8'(d); lp_enter = 5'(lp);
    {bus_release, sleep_exec, exc_enter, flash_rd} = 4'(ev);
    step();
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    go(1, 0, 0, 0, 0, 0, 0, 0);
    go(1, 0, 0, 0, 0, 0, 0, 0);      // R1 reset state
    go(0, 0, 1, 0, 0, 8'h02, 0, 0);  // R3 mode without gate
    go(0, 0, 1, 0, 0, 8'h03, 0, 0);  // R3 gate not yet open
    go(0, 0, 1, 1, 0, 8'h01, 0, 0);  // open gate
    go(0, 0, 1, 1, 0, 8'h03, 0, 0);  // R3 program starts
    go(0, 0, 1, 1, 0, 8'h07, 0, 0);  // R4 both rejected
    go(0, 0, 0, 1, 0, 0, 0, 0);      // R9 readback
    go(0, 0, 0, 0, 0, 0, 1, 0);      // R6 flash read trap
    go(0, 0, 1, 1, 0, 8'h03, 0, 0);  // R8 ignored
    go(0, 0, 1, 1, 1, 8'h00, 0, 0);  // R8 status write ignored
    go(0, 0, 0, 1, 1, 0, 0, 0);
    go(0, 1, 0, 0, 0, 0, 0, 0);      // R1 watchdog reset
    go(0, 0, 0, 0, 0, 0, 15, 0);     // R7 strobes idle
    go(0, 0, 1, 0, 2, 8'hA5, 0, 0);  // R5 mask
    go(0, 0, 1, 0, 3, 8'h3C, 0, 0);
    go(0, 0, 1, 0, 0, 8'h01, 0, 0);
    go(0, 0, 1, 0, 0, 8'h05, 0, 0);  // R5 erase on
    go(0, 0, 1, 1, 2, 8'h00, 0, 0);  // R5 zero low mask
    go(0, 0, 0, 1, 3, 0, 0, 4);      // R2 low-power
    go(0, 0, 0, 1, 2, 0, 0, 0);
    for (int e = 0; e < 4; e++) begin // R6 each strobe
      go(1, 0, 0, 0, 0, 0, 0, 0);
      go(0, 0, 1, 0, 0, 8'h01, 0, 0);
      go(0, 0, 1, 0, 0, (e % 2) ? 8'h05 : 8'h03, 0, 0);
      go(0, 0, 0, 0, 0, 0, 1 << e, 0);
      go(0, 0, 0, 1, 1, 0, 0, 0);
    end
    go(1, 0, 0, 0, 0, 0, 0, 0);       // R10 trap with low-power entry
    go(0, 0, 1, 0, 0, 8'h01, 0, 0);
    go(0, 0, 1, 0, 0, 8'h03, 0, 0);
    go(0, 0, 1, 0, 2, 8'hFF, 4, 1);
    go(0, 0, 0, 1, 2, 0, 0, 0);
    for (int n = 0; n < 6000; n++) begin
      int r, d;
      r = $urandom % 1000;
      case ($urandom % 8)
        0: d = 8'h01; 1: d = 8'h03; 2: d = 8'h05; 3: d = 8'h07;
        4: d = 8'h00; 5: d = 8'h06; default: d = $urandom % 256;
      endcase
      go(r < 5, r >= 5 && r < 8, ($urandom % 3) == 0, ($urandom % 2) == 0,
         $urandom % 4, d,
         {($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0, ($urandom % 12) == 0},
         (($urandom % 40) == 0) ? (1 << ($urandom % 5)) : 0);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule